// File: doc/BRIEF.md
# Serial EEPROM Single-Address Erase Sequencer

This block is the master side of a three-wire serial EEPROM link: chip select, serial clock, data toward the memory, and one data line read back from it. A single strobe with an address starts one erase of that location. The controller sends the start bit, the erase opcode and the address. It launches the memory's internal self-timed cycle and polls the ready/busy indication until the memory reports that it has finished. It then clears that indication and reports the result to the user side with a one-cycle done pulse, or with a one-cycle error pulse if the memory never became ready.

The serial clock comes from the system clock through a divider. The minimum chip-select low time is derived from the system clock period so that it is never shorter than 250 ns. A mode input serves memories that start their internal write on the clock rise before the last address bit instead of on the chip-select fall. In that mode the controller still sends the complete frame, but its write-cycle indication and its timeout window begin at that earlier point.

Top module: `mw_erase_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, chip select, serial clock, data-out-to-memory, busy, done, error and write-cycle outputs are all 0.
- R2: A start strobe in idle raises busy in the following cycle. Busy stays high until the cycle that carries the done or error pulse. A start strobe while busy is ignored: it neither changes the frame in flight nor queues a second operation.
- R3: With chip select high, the memory samples on successive serial clock rises exactly ADDR_W+3 bits. These are 1, 1, 1 (start bit and the erase opcode 11), then the address from its most significant bit down to bit 0.
- R4: The data line toward the memory changes only while the serial clock is low. Its value at every serial clock rise equals its value one system cycle earlier.
- R5: The serial clock is low whenever chip select is low. After the last address bit, the serial clock returns low and then chip select falls. Every low phase of chip select that ends in a rise lasts at least ceil(250 ns / clock period) system cycles.
- R6: After the launch low time, chip select rises once and stays high with no serial clock pulses for as long as the memory's data-out reads 0 (busy).
- R7: When data-out reads 1 (ready), the controller gives exactly one serial clock pulse with data at 1 while chip select is high, then drops chip select. After chip select has stayed low for the minimum low time, done pulses and busy falls.
- R8: The write-cycle output rises in the cycle chip select falls after the frame in the default mode. With the early-launch input at 1, it rises together with the serial clock rise that samples address bit 1 instead.
- R9: If ready is not seen within TIMEOUT_CYC system cycles of the write-cycle output rising, chip select is dropped. After the minimum low time, error pulses, busy falls and no done pulse is given. The next operation runs normally.
- R10: Done and error are single-cycle pulses, never both high, with exactly one of them per accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Erase request strobe, taken only while idle |
| addr_i | input | ADDR_W | Location to erase, sampled with the strobe |
| early_launch_i | input | 1 | 1: memory begins its write cycle on the clock rise before the last address bit |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: erase finished and status cleared |
| err_o | output | 1 | One-cycle pulse: ready not seen within the timeout |
| wcyc_o | output | 1 | Memory's self-timed cycle is taken to be running |
| mw_cs_o | output | 1 | Chip select to the memory |
| mw_sk_o | output | 1 | Serial clock to the memory |
| mw_di_o | output | 1 | Serial data to the memory |
| mw_do_i | input | 1 | Serial data / ready-busy from the memory |

## Verification
The embedded assertions assume that reset is applied from time zero. They also assume that the memory drives its ready/busy level only from its own state and chip select, so that the level settles within one divider period after chip select rises, when the controller first samples it. The bench's memory model follows this rule. It updates data-out only on the system clock's falling edge, reports busy for a fixed stretch after launch, and can be told never to become ready. Start strobes are given in idle, except in one scenario that deliberately repeats the strobe with a different address while an erase is in flight.

// File: rtl/mw_erase_pkg.sv
// Shared types and constants for the serial EEPROM erase sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package mw_erase_pkg;

    // Sequencer phases, in the order an operation visits them.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start strobe
        ST_SHIFT,  // clocking out start bit, opcode and address
        ST_DROP,   // serial clock low, chip select goes low (launch)
        ST_LOWW,   // holding chip select low for the minimum time
        ST_POLL,   // chip select high, sampling ready/busy
        ST_CLRS,   // one clock pulse with data 1 to clear the status
        ST_CLRD,   // chip select low after the clear (or after a timeout)
        ST_ENDW    // final minimum low time, then report
    } mw_state_e;

    // Header sent ahead of the address: start bit then erase opcode.
    localparam logic [2:0] ERASE_HDR = 3'b111;

    // Number of serial bits in one erase frame.
    function automatic int frame_bits(input int aw);
        return aw + 3;
    endfunction

endpackage

// File: rtl/mw_tick_gen.sv
// Divider that produces one-cycle ticks every DIV system cycles while enabled.
// Assumes: DIV >= 1; the count restarts from zero whenever en_i is low, so the
// first tick comes DIV cycles after enabling.
module mw_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count system cycles up to the divider limit, restarting when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/mw_wait_timer.sv
// Saturating cycle counter: done_o is high once LIMIT cycles of en_i have been
// counted since the last clear (the clear cycle counts as the first).
// Assumes: LIMIT >= 1; clr_i has priority over en_i.
module mw_wait_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic done_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Advance while enabled and stop at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (en_i && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == TOP);

endmodule

// File: rtl/mw_frame_shift.sv
// Frame register for one erase: loads header plus address and presents the
// current serial bit, most significant first.
// Assumes: adv_i is never raised while last_o is high.
module mw_frame_shift
    import mw_erase_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adv_i,
    output logic              bit_o,
    output logic              last_o,
    output logic              pre_last_o
);
    localparam int NB = frame_bits(ADDR_W);
    localparam int IW = $clog2(NB);

    logic [NB-1:0] sr_q;
    logic [IW-1:0] idx_q;

    // Load a new frame or move on to the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sr_q  <= {ERASE_HDR, addr_i};
            idx_q <= '0;
        end else if (adv_i) begin
            sr_q  <= {sr_q[NB-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_o      = sr_q[NB-1];
    assign last_o     = (idx_q == IW'(NB - 1));
    assign pre_last_o = (idx_q == IW'(NB - 2));

    // R3: the frame never advances beyond its final bit.
    p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> !last_o);

endmodule

// File: rtl/mw_erase_ctrl.sv
// Top of the serial EEPROM erase sequencer. Sends start bit, erase opcode and
// address, launches the self-timed cycle by dropping chip select, polls
// ready/busy with chip select high, clears the status with a start bit and a
// deselect, then reports done or a timeout error.
// Assumes: the memory drives mw_do_i from its own state and chip select and
// settles within CLK_DIV cycles after chip select rises.
module mw_erase_ctrl
    import mw_erase_pkg::*;
#(
    parameter int ADDR_W        = 7,
    parameter int CLK_DIV       = 4,
    parameter int CLK_PERIOD_PS = 8000,
    parameter int CSL_MIN_PS    = 250000,
    parameter int TIMEOUT_CYC   = 800000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              early_launch_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              wcyc_o,
    output logic              mw_cs_o,
    output logic              mw_sk_o,
    output logic              mw_di_o,
    input  logic              mw_do_i
);
    localparam int CSL_RAW = (CSL_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int CSL_CYC = (CSL_RAW < 1) ? 1 : CSL_RAW;

    mw_state_e state_q;
    logic      cs_q, sk_q, busy_q, done_q, err_q, wcyc_q, fail_q;
    logic      tick, tick_en;
    logic      low_clr, low_en, low_done;
    logic      to_clr, to_done;
    logic      sh_load, sh_adv, sh_bit, sh_last, sh_prelast;

    assign tick_en = (state_q == ST_SHIFT) || (state_q == ST_POLL) || (state_q == ST_CLRS);
    assign low_clr = (state_q == ST_DROP) || (state_q == ST_CLRD);
    assign low_en  = (state_q == ST_LOWW) || (state_q == ST_ENDW);
    assign to_clr  = (state_q == ST_IDLE);
    assign sh_load = (state_q == ST_IDLE) && start_i;
    assign sh_adv  = (state_q == ST_SHIFT) && tick && sk_q && !sh_last;

    mw_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en_i(tick_en), .tick_o(tick)
    );

    mw_wait_timer #(.LIMIT(CSL_CYC)) u_low_timer (
        .clk(clk), .rst_n(rst_n), .clr_i(low_clr), .en_i(low_en), .done_o(low_done)
    );

    mw_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timeout (
        .clk(clk), .rst_n(rst_n), .clr_i(to_clr), .en_i(wcyc_q), .done_o(to_done)
    );

    mw_frame_shift #(.ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .load_i(sh_load), .addr_i(addr_i),
        .adv_i(sh_adv), .bit_o(sh_bit), .last_o(sh_last), .pre_last_o(sh_prelast)
    );

    // Select the serial data: frame bit while shifting, 1 for the clear pulse.
    always_comb begin
        case (state_q)
            ST_SHIFT: mw_di_o = sh_bit;
            ST_CLRS:  mw_di_o = 1'b1;
            default:  mw_di_o = 1'b0;
        endcase
    end

    // Sequence one erase operation from strobe to report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_q    <= 1'b0;
            sk_q    <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            wcyc_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (to_done && ((state_q == ST_LOWW) || (state_q == ST_POLL))) begin
                cs_q    <= 1'b0;
                fail_q  <= 1'b1;
                state_q <= ST_CLRD;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (start_i) begin
                            cs_q    <= 1'b1;
                            busy_q  <= 1'b1;
                            fail_q  <= 1'b0;
                            state_q <= ST_SHIFT;
                        end
                    end
                    ST_SHIFT: begin
                        if (tick && !sk_q) begin
                            sk_q <= 1'b1;
                            if (early_launch_i && sh_prelast) begin
                                wcyc_q <= 1'b1;
                            end
                        end else if (tick && sk_q) begin
                            sk_q <= 1'b0;
                            if (sh_last) begin
                                state_q <= ST_DROP;
                            end
                        end
                    end
                    ST_DROP: begin
                        cs_q    <= 1'b0;
                        wcyc_q  <= 1'b1;
                        state_q <= ST_LOWW;
                    end
                    ST_LOWW: begin
                        if (low_done) begin
                            cs_q    <= 1'b1;
                            state_q <= ST_POLL;
                        end
                    end
                    ST_POLL: begin
                        if (tick && mw_do_i) begin
                            state_q <= ST_CLRS;
                        end
                    end
                    ST_CLRS: begin
                        if (tick && !sk_q) begin
                            sk_q <= 1'b1;
                        end else if (tick && sk_q) begin
                            sk_q    <= 1'b0;
                            state_q <= ST_CLRD;
                        end
                    end
                    ST_CLRD: begin
                        cs_q    <= 1'b0;
                        state_q <= ST_ENDW;
                    end
                    ST_ENDW: begin
                        if (low_done) begin
                            busy_q  <= 1'b0;
                            wcyc_q  <= 1'b0;
                            done_q  <= !fail_q;
                            err_q   <= fail_q;
                            state_q <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign mw_cs_o = cs_q;
    assign mw_sk_o = sk_q;
    assign busy_o  = busy_q;
    assign done_o  = done_q;
    assign err_o   = err_q;
    assign wcyc_o  = wcyc_q;

    // ---------------- assertions ----------------
    localparam int LW = $clog2(CSL_CYC + 2);
    logic [LW-1:0] low_run_q;
    logic          seen_hi_q;

    // Track how long chip select has been low, for the minimum-low check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q <= '0;
            seen_hi_q <= 1'b0;
        end else begin
            seen_hi_q <= seen_hi_q || cs_q;
            if (cs_q) begin
                low_run_q <= '0;
            end else if (low_run_q != LW'(CSL_CYC)) begin
                low_run_q <= low_run_q + 1'b1;
            end
        end
    end

    // R5: chip select low for at least the minimum time before each re-rise.
    p_cs_low_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mw_cs_o) && seen_hi_q) |-> (low_run_q >= LW'(CSL_CYC)));

    // R5: no serial clock while deselected.
    p_sk_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mw_cs_o |-> !mw_sk_o);

    // R4: data toward the memory is steady across each clock rise.
    p_di_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_sk_o) |-> $stable(mw_di_o));

    // R2: busy only ends together with a report.
    p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o || err_o));

    // R10: done and error never together.
    p_report_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R10: done lasts one cycle.
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: every chip-select fall happens with the write cycle already marked.
    p_launch_marked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mw_cs_o) |-> wcyc_o);

endmodule

// File: tb/mw_erase_ctrl_tb.sv
module mw_erase_ctrl_tb;
    localparam int AW    = 7;
    localparam int NB    = AW + 3;
    localparam int DIV   = 2;
    localparam int CSL   = 32;     // ceil(250 ns / 8 ns)
    localparam int TO    = 2000;
    localparam int BUSY  = 500;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          early = 1'b0;
    logic          busy, done, err, wcyc, cs, sk, di, dout;

    always #4 clk = ~clk;

    mw_erase_ctrl #(
        .ADDR_W(AW), .CLK_DIV(DIV), .CLK_PERIOD_PS(8000),
        .CSL_MIN_PS(250000), .TIMEOUT_CYC(TO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
        .early_launch_i(early), .busy_o(busy), .done_o(done), .err_o(err),
        .wcyc_o(wcyc), .mw_cs_o(cs), .mw_sk_o(sk), .mw_di_o(di), .mw_do_i(dout)
    );

    int checks = 0;
    int errors = 0;

    // memory model and pin monitor state
    logic          st_phase = 1'b0, never_rdy = 1'b0, clear_seen = 1'b0, cleared = 1'b0;
    int            rdy_cnt = 0;
    int            nbits = 0;
    logic [NB-1:0] frame = '0;
    logic          wc_a1 = 1'b0, wc_a2 = 1'b0, wc_fall = 1'b0;
    int            poll_rises = 0, poll_sk = 0, poll_drop = 0, di_bad = 0;
    int            min_low = 1000000, low_run = 0;
    logic          armed = 1'b0;
    logic          p_sk = 1'b0, p_cs = 1'b0, p_di = 1'b0, p_wcyc = 1'b0;
    int            cyc = 0, wrise = 0, err_at = 0, done_cnt = 0, err_cnt = 0;

    assign dout = cs && st_phase && (rdy_cnt == 0) && !never_rdy;

    // Model the memory and observe the pins between clock edges.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sk && !p_sk) begin
            if (di != p_di) di_bad = di_bad + 1;
            if (cs) begin
                if (st_phase) begin
                    poll_sk = poll_sk + 1;
                    if (di) clear_seen = 1'b1;
                end else begin
                    frame = {frame[NB-2:0], di};
                    nbits = nbits + 1;
                    if (nbits == NB - 2) wc_a2 = wcyc;
                    if (nbits == NB - 1) wc_a1 = wcyc;
                end
            end
        end
        if (!cs && p_cs) begin
            if (!st_phase && nbits == NB) begin
                st_phase = 1'b1;
                rdy_cnt  = BUSY;
                wc_fall  = wcyc;
            end else if (st_phase && clear_seen) begin
                st_phase = 1'b0;
                cleared  = 1'b1;
            end else if (st_phase) begin
                poll_drop = poll_drop + 1;
            end
        end
        if (cs && !p_cs && st_phase) poll_rises = poll_rises + 1;
        if (rdy_cnt > 0) rdy_cnt = rdy_cnt - 1;
        if (!cs) begin
            low_run = low_run + 1;
        end else begin
            if (!p_cs && armed && low_run < min_low) min_low = low_run;
            low_run = 0;
            armed   = 1'b1;
        end
        if (wcyc && !p_wcyc) wrise = cyc;
        if (done) done_cnt = done_cnt + 1;
        if (err) begin
            err_cnt = err_cnt + 1;
            err_at  = cyc;
        end
        p_sk = sk; p_cs = cs; p_di = di; p_wcyc = wcyc;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        nbits = 0; frame = '0; clear_seen = 1'b0; cleared = 1'b0;
        wc_a1 = 1'b0; wc_a2 = 1'b0; wc_fall = 1'b0;
        poll_rises = 0; poll_sk = 0; poll_drop = 0; di_bad = 0;
        min_low = 1000000; done_cnt = 0; err_cnt = 0;
    endtask

    task automatic wait_report();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (done_cnt != 0 || err_cnt != 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    // R1: outputs quiet during and just after reset.
    task automatic t_reset();
        start = 1'b1;
        repeat (4) @(negedge clk);
        chk(!cs && !sk && !di && !busy && !done && !err && !wcyc, "R1 in reset",
            {cs, sk, di, busy, done, err, wcyc}, 0);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cs && !sk && !di && !busy && !done && !err && !wcyc, "R1 after reset",
            {cs, sk, di, busy, done, err, wcyc}, 0);
        repeat (40) @(negedge clk);
    endtask

    // R2 R3 R4 R5 R6 R7 R8 R10: one full erase.
    task automatic t_erase(input logic [AW-1:0] a, input logic mode);
        clear_model();
        early = mode;
        @(negedge clk);
        start = 1'b1; addr = a;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after strobe", busy, 1);
        wait_report();
        chk(frame == {3'b111, a} && nbits == NB, "R3 frame bits", frame, {3'b111, a});
        chk(di_bad == 0, "R4 data stable at rise", di_bad, 0);
        chk(min_low >= CSL, "R5 chip select low time", min_low, CSL);
        chk(poll_rises == 1 && poll_drop == 0, "R6 single poll window", poll_rises, 1);
        chk(poll_sk == 1 && cleared, "R7 status clear pulse", poll_sk, 1);
        chk(done_cnt == 1 && !busy, "R7 done and busy low", done_cnt, 1);
        chk(err_cnt == 0, "R10 no error on success", err_cnt, 0);
        if (mode)
            chk(wc_a1 && !wc_a2, "R8 early launch point", {wc_a2, wc_a1}, 1);
        else
            chk(!wc_a1 && wc_fall, "R8 launch at deselect", {wc_a1, wc_fall}, 1);
    endtask

    // R2: a second strobe while busy is dropped.
    task automatic t_ignore();
        clear_model();
        early = 1'b0;
        @(negedge clk);
        start = 1'b1; addr = 7'h2C;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1; addr = 7'h53;
        @(negedge clk);
        start = 1'b0;
        wait_report();
        chk(frame == {3'b111, 7'h2C}, "R2 frame unchanged by extra strobe", frame, {3'b111, 7'h2C});
        repeat (60) @(negedge clk);
        chk(!busy && !cs && done_cnt == 1, "R2 no queued operation", {busy, cs}, 0);
    endtask

    // R9: timeout when ready never appears, then recovery.
    task automatic t_timeout();
        clear_model();
        never_rdy = 1'b1;
        early = 1'b0;
        @(negedge clk);
        start = 1'b1; addr = 7'h11;
        @(negedge clk);
        start = 1'b0;
        wait_report();
        chk(err_cnt == 1 && done_cnt == 0, "R9 error without done", err_cnt, 1);
        chk(!busy && !cs, "R9 idle and deselected", {busy, cs}, 0);
        chk((err_at - wrise) >= TO && (err_at - wrise) <= TO + CSL + 8,
            "R9 timeout window", err_at - wrise, TO);
        never_rdy = 1'b0;
        st_phase  = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_erase(7'h5A, 1'b0);
        t_erase(7'h00, 1'b0);
        t_erase(7'h7F, 1'b1);
        t_erase(7'h41, 1'b1);
        t_ignore();
        t_timeout();
        t_erase(7'h26, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule